// File: doc/BRIEF.md
# Table-Driven State Machine Engine

This block is a synchronous state machine in which every transition and every output bit comes from one lookup table rather than from dedicated gates. The current state and the registered input sample are joined into a table address; the addressed word supplies the next state and the output bits. Because the output field is looked up with the input sample as part of the address, an output may depend on the input as well as on the state, so Mealy machines can be programmed as easily as Moore machines.

Inputs pass through a buffer register before they reach the table. Outputs leave through an output register. As a result, both sides change only on clock edges, and the table word has a whole cycle to settle. The table is held in flops. Each reset cycle in which the write enable is low reloads the built-in program. Each reset cycle in which the write enable is high replaces one word. Outside reset the table is frozen.

The built-in program is a 3-bit counter that steps by three. Input bit 0 is the advance control. The named states are the counts S0, S3, S6, S1, S4, S7, S2 and S5, visited in that order. Each state moves to the next one on the list when bit 0 is 1, the move from S5 wraps back to S0, and a state holds when bit 0 is 0.

Top module: `tde_engine`

## Requirements
- R1: While synchronous active-high reset is sampled high, the state register, input buffer and output register become zero at the next edge.
- R2: The table address is {state, sampled inputs}, with the state in the upper bits. In each word, the upper ST_W bits are the next state and the lower OUT_W bits are the output.
- R3: With the built-in program, input bit 0 = 1 moves the count by 3 modulo 8 (0,3,6,1,4,7,2,5,0), and bit 0 = 0 holds it. The output field of every built-in word equals its next-state field.
- R4: A change on the inputs reaches the state register two clock edges after it is applied: one edge for the buffer and one for the state. The output register updates on the same edge as the state.
- R5: The output is taken from the addressed word, so one state may drive different outputs for different input samples (Mealy behaviour).
- R6: A write enable asserted while reset is low has no effect on the table.
- R7: A reset cycle with the write enable low reloads the whole built-in program. A reset cycle with the write enable high writes wr_data into the single word at wr_addr, and the other words keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also opens table loading |
| in_bits | input | IN_W | Machine inputs, registered before use |
| wr_en | input | 1 | Table write or reload control, honoured only in reset |
| wr_addr | input | ST_W+IN_W | Word address for a table write |
| wr_data | input | ST_W+OUT_W | Word to write: next state above output |
| cur_state | output | ST_W | Current state register |
| out_bits | output | OUT_W | Registered output field |

## Verification
An input applied before edge n is captured at edge n and decides the state and output values that appear after edge n+1. The bench therefore compares the state and output of each step against what the input applied one step earlier predicts. Every sample is taken 1 ns after the rising edge, so all registers have settled and no input change is near an edge. Reset clearing and table writes take effect at the next edge, so they are checked one step after the reset cycle. A write attempted outside reset is checked by reading the targeted word through the normal running path on the following edges.

// File: rtl/tde_pkg.sv
`timescale 1ns/1ps
package tde_pkg;
    // stride of the built-in counter program
    localparam int unsigned COUNT_STEP = 3;
    // input bit that gates advancing in the built-in program
    localparam int unsigned ADV_BIT = 0;
endpackage

// File: rtl/tde_sample_reg.sv
`timescale 1ns/1ps
module tde_sample_reg #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/tde_table_store.sv
`timescale 1ns/1ps
module tde_table_store #(
    parameter int ST_W  = 3,
    parameter int IN_W  = 1,
    parameter int OUT_W = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ST_W+IN_W-1:0]     wr_addr,
    input  logic [ST_W+OUT_W-1:0]    wr_data,
    input  logic [ST_W+IN_W-1:0]     rd_addr,
    output logic [ST_W+OUT_W-1:0]    rd_data
);
    localparam int ADDR_W = ST_W + IN_W;
    localparam int WORD_W = ST_W + OUT_W;
    localparam int DEPTH  = 1 << ADDR_W;

    // built-in program: advance by the stride when the gating input bit is set
    function automatic logic [WORD_W-1:0] dflt_word(int unsigned idx);
        int unsigned st_v;
        int unsigned adv;
        int unsigned nxt;
        st_v = idx >> IN_W;
        adv  = (((idx >> tde_pkg::ADV_BIT) & 1) != 0) ? tde_pkg::COUNT_STEP : 0;
        nxt  = (st_v + adv) % (1 << ST_W);
        return {ST_W'(nxt), OUT_W'(nxt)};
    endfunction

    function automatic logic [DEPTH*WORD_W-1:0] dflt_image();
        logic [DEPTH*WORD_W-1:0] img;
        img = '0;
        for (int i = 0; i < DEPTH; i++) img[i*WORD_W +: WORD_W] = dflt_word(i);
        return img;
    endfunction

    localparam logic [DEPTH*WORD_W-1:0] DFLT_IMAGE = dflt_image();

    logic [WORD_W-1:0]       cells [DEPTH];
    logic [DEPTH*WORD_W-1:0] image;

    // storage changes only while reset is sampled high
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!wr_en)
                    cells[i] <= DFLT_IMAGE[i*WORD_W +: WORD_W];
                else if (wr_addr == ADDR_W'(i))
                    cells[i] <= wr_data;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) image[i*WORD_W +: WORD_W] = cells[i];
    end

    assign rd_data = cells[rd_addr];

    // R6
    table_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(image));

    // R7
    default_reload_chk: assert property (@(posedge clk)
        (rst && !wr_en) |=> (image == DFLT_IMAGE));

    // R7
    word_write_chk: assert property (@(posedge clk)
        (rst && wr_en) |=> (cells[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/tde_engine.sv
`timescale 1ns/1ps
module tde_engine #(
    parameter int ST_W  = 3,
    parameter int IN_W  = 1,
    parameter int OUT_W = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IN_W-1:0]       in_bits,
    input  logic                  wr_en,
    input  logic [ST_W+IN_W-1:0]  wr_addr,
    input  logic [ST_W+OUT_W-1:0] wr_data,
    output logic [ST_W-1:0]       cur_state,
    output logic [OUT_W-1:0]      out_bits
);
    localparam int ADDR_W = ST_W + IN_W;
    localparam int WORD_W = ST_W + OUT_W;

    logic [IN_W-1:0]   in_q;
    logic [ST_W-1:0]   st_q;
    logic [OUT_W-1:0]  out_q;
    logic [ADDR_W-1:0] tbl_addr;
    logic [WORD_W-1:0] tbl_word;

    tde_sample_reg #(.W(IN_W)) in_buf_i (
        .clk (clk),
        .rst (rst),
        .d   (in_bits),
        .q   (in_q)
    );

    assign tbl_addr = {st_q, in_q};

    tde_table_store #(.ST_W(ST_W), .IN_W(IN_W), .OUT_W(OUT_W)) table_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (tbl_addr),
        .rd_data (tbl_word)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= tbl_word[WORD_W-1 -: ST_W];
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= tbl_word[OUT_W-1:0];
    end

    assign cur_state = st_q;
    assign out_bits  = out_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (st_q == '0 && in_q == '0 && out_q == '0));
endmodule

// File: tb/tde_engine_tb_top.sv
`timescale 1ns/1ps
module tde_engine_tb_top;
    localparam int ST_W  = 3;
    localparam int IN_W  = 1;
    localparam int OUT_W = 3;
    localparam int NVEC  = 17;

    // each entry: {advance input, expected state and output after the edge}
    localparam logic [3:0] VEC [NVEC] = '{
        {1'b1,3'd0}, {1'b1,3'd3}, {1'b1,3'd6}, {1'b1,3'd1}, {1'b1,3'd4},
        {1'b1,3'd7}, {1'b1,3'd2}, {1'b1,3'd5}, {1'b1,3'd0}, {1'b0,3'd3},
        {1'b0,3'd3}, {1'b1,3'd3}, {1'b0,3'd6}, {1'b1,3'd6}, {1'b1,3'd1},
        {1'b0,3'd4}, {1'b0,3'd4}
    };

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [IN_W-1:0]       in_bits = '0;
    logic                  wr_en = 1'b0;
    logic [ST_W+IN_W-1:0]  wr_addr = '0;
    logic [ST_W+OUT_W-1:0] wr_data = '0;
    logic [ST_W-1:0]       cur_state;
    logic [OUT_W-1:0]      out_bits;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tde_engine #(.ST_W(ST_W), .IN_W(IN_W), .OUT_W(OUT_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_bits   (in_bits),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cur_state (cur_state),
        .out_bits  (out_bits)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [2:0] exp_st, logic [2:0] exp_out);
        checks++;
        if (cur_state !== exp_st || out_bits !== exp_out) begin
            errors++;
            $display("FAIL %s: state=%0d out=%0d expected state=%0d out=%0d",
                     req, cur_state, out_bits, exp_st, exp_out);
        end
    endtask

    initial begin
        // R1: reset state, two reset cycles also load the built-in program
        tick();
        tick();
        check("R1 reset", 3'd0, 3'd0);

        // R3 R4: walk the counter vectors
        rst = 1'b0;
        for (int k = 0; k < NVEC; k++) begin
            in_bits = VEC[k][3];
            tick();
            check("R3/R4 counter vector", VEC[k][2:0], VEC[k][2:0]);
        end

        // R1: reset in mid run (state 4) clears to zero
        in_bits = 1'b0;
        rst = 1'b1;
        tick();
        check("R1 mid-run reset", 3'd0, 3'd0);

        // R7: write three custom words during reset; word = {next, out}
        wr_en = 1'b1;
        wr_addr = 4'd1;  wr_data = {3'd5, 3'd6}; tick();
        wr_addr = 4'd10; wr_data = {3'd5, 3'd1}; tick();
        wr_addr = 4'd11; wr_data = {3'd0, 3'd7}; tick();
        wr_en = 1'b0;
        rst = 1'b0;

        // R2 R4 R5: run the custom program
        in_bits = 1'b1; tick();
        check("R4 input not yet seen", 3'd0, 3'd0);
        in_bits = 1'b0; tick();
        check("R7 written word {0,1}", 3'd5, 3'd6);
        in_bits = 1'b1; tick();
        check("R5 state5 input0 output", 3'd5, 3'd1);
        in_bits = 1'b0; tick();
        check("R5 state5 input1 output", 3'd0, 3'd7);
        tick();
        check("R2 unwritten word keeps default", 3'd0, 3'd0);

        // R6: writes outside reset are ignored (word 0 would become {7,7})
        wr_en = 1'b1; wr_addr = 4'd0; wr_data = {3'd7, 3'd7};
        tick();
        check("R6 write outside reset", 3'd0, 3'd0);
        tick();
        check("R6 write outside reset", 3'd0, 3'd0);
        wr_en = 1'b0;
        tick();
        check("R6 write outside reset", 3'd0, 3'd0);

        // R7: reset with write enable low restores the built-in program
        rst = 1'b1; tick();
        rst = 1'b0; in_bits = 1'b1; tick();
        check("R7 reload", 3'd0, 3'd0);
        tick();
        check("R7 reload word {0,1}", 3'd3, 3'd3);
        tick();
        check("R3 reload step", 3'd6, 3'd6);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule